// File: doc/BRIEF.md
# Three-bit Gray sequence counter with state decoder

This block is a three-bit synchronous counter whose state walks a reflected Gray sequence, so that only one state bit moves on any counting edge. Each state bit is kept in its own JK-style storage cell. All cells share one clock. The J and K inputs of each cell come from fixed excitation equations on the present state. The design does not count in binary and then convert to Gray.

Beside the state, the block drives eight decode lines, one for each possible state. A single polarity input makes all eight lines active-high or all eight active-low. Downstream logic can take a per-state strobe directly in whichever sense it needs. The counter advances only while the enable input is high, and a synchronous reset returns it to zero.

Top module: `gray3_jk_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state_q` becomes 3'b000 after that edge, whatever `step_en` is.
- R2: When `rst` is low and `step_en` is low at a rising edge, `state_q` keeps its value.
- R3: When `rst` is low and `step_en` is high at a rising edge, `state_q` moves to its successor in the cycle 000 -> 001 -> 011 -> 010 -> 110 -> 111 -> 101 -> 100, and from 100 it returns to 000.
- R4: Each counting edge changes exactly one bit of `state_q`, and this includes the wrap from 100 to 000.
- R5: With `low_active` = 0, decode line `hit_o[k]` is 1 exactly when `state_q`, read as an unsigned binary number, equals k. All other lines are 0.
- R6: With `low_active` = 1, `hit_o[k]` is 0 exactly when `state_q` equals k. All other lines are 1.
- R7: In every state and under either polarity, exactly one decode line is in its active level.
- R8: A change of `low_active` alters `hit_o` in the same cycle, with no clock edge, and leaves `state_q` unchanged.
- R9: Each state bit is updated as a JK cell. J=0,K=0 holds the bit, J=1,K=0 sets it, J=0,K=1 clears it, and J=1,K=1 inverts it. The excitations are as follows:
  - bit 2: J = q1 & ~q0 and K = ~q1 & ~q0
  - bit 1: J = ~q2 & q0 and K = q2 & q0
  - bit 0: J = ~(q2 ^ q1) and K = q2 ^ q1

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all storage cells |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the sequence on this edge when high |
| low_active | input | 1 | 0: decode lines active-high; 1: active-low |
| state_q | output | 3 | Present Gray-coded state |
| hit_o | output | 8 | One decode line per state, index = state value |

## Verification
The clocked properties assume that `rst` is held high through the first clock edge, so that the state is defined before any step or hold property is armed. They also assume that `step_en` and `low_active` are stable around each rising edge. The stimulus raises reset from time zero. It changes every input only on falling edges, and it reads the outputs one nanosecond after each rising edge. The enable patterns cover long runs, isolated holds and holds at the wrap point. Reset is applied while counting is enabled, and the polarity is flipped while the counter holds still.

// File: rtl/gray3_pkg.sv
`timescale 1ns/1ps
package gray3_pkg;

    localparam int CODE_W     = 3;
    localparam int NUM_STATES = 1 << CODE_W;

    typedef logic [CODE_W-1:0]     code_t;
    typedef logic [NUM_STATES-1:0] line_t;

    // excitation pair for one storage cell
    typedef struct packed {
        logic j;
        logic k;
    } jk_t;

    typedef jk_t [CODE_W-1:0] jk_vec_t;

    typedef enum logic {
        POL_HIGH = 1'b0,
        POL_LOW  = 1'b1
    } pol_e;

    // JK storage rule: hold, clear, set, invert
    function automatic logic jk_apply(input logic q, input jk_t e);
        logic nq;
        unique case ({e.j, e.k})
            2'b00:   nq = q;
            2'b01:   nq = 1'b0;
            2'b10:   nq = 1'b1;
            default: nq = ~q;
        endcase
        return nq;
    endfunction

    // arithmetic successor in reflected Gray order (used by checks only)
    function automatic code_t gray_succ(input code_t g);
        code_t b;
        b[CODE_W-1] = g[CODE_W-1];
        for (int i = CODE_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        b = b + code_t'(1);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/gray3_excite.sv
`timescale 1ns/1ps
module gray3_excite
    import gray3_pkg::*;
(
    input  code_t   cur,
    output jk_vec_t exc
);

    always_comb begin
        // most significant bit
        exc[2].j = cur[1] & ~cur[0];
        exc[2].k = ~cur[1] & ~cur[0];
        // middle bit
        exc[1].j = ~cur[2] & cur[0];
        exc[1].k = cur[2] & cur[0];
        // least significant bit
        exc[0].j = ~(cur[2] ^ cur[1]);
        exc[0].k = cur[2] ^ cur[1];
    end

endmodule

// File: rtl/gray3_jk_cell.sv
`timescale 1ns/1ps
module gray3_jk_cell
    import gray3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  jk_t  exc,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (adv) begin
            q <= jk_apply(q, exc);
        end
    end

endmodule

// File: rtl/gray3_state_decode.sv
`timescale 1ns/1ps
module gray3_state_decode
    import gray3_pkg::*;
(
    input  code_t cur,
    input  pol_e  pol,
    output line_t lines
);

    localparam logic INVERT_LOW = 1'b1;

    for (genvar s = 0; s < NUM_STATES; s++) begin : g_line
        logic match;
        assign match    = (cur == code_t'(s));
        assign lines[s] = (pol == POL_LOW) ? (match ^ INVERT_LOW) : match;
    end

endmodule

// File: rtl/gray3_jk_counter.sv
`timescale 1ns/1ps
module gray3_jk_counter
    import gray3_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step_en,
    input  logic                  low_active,
    output logic [CODE_W-1:0]     state_q,
    output logic [NUM_STATES-1:0] hit_o
);

    code_t   cur;
    jk_vec_t exc;
    pol_e    pol;

    assign pol = pol_e'(low_active);

    gray3_excite u_excite (
        .cur (cur),
        .exc (exc)
    );

    for (genvar b = 0; b < CODE_W; b++) begin : g_cell
        gray3_jk_cell u_cell (
            .clk (clk),
            .rst (rst),
            .adv (step_en),
            .exc (exc[b]),
            .q   (cur[b])
        );
    end

    gray3_state_decode u_decode (
        .cur   (cur),
        .pol   (pol),
        .lines (hit_o)
    );

    assign state_q = cur;

endmodule

// File: rtl/gray3_jk_counter_chk.sv
`timescale 1ns/1ps
module gray3_jk_counter_chk
    import gray3_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  step_en,
    input logic                  low_active,
    input logic [CODE_W-1:0]     state_q,
    input logic [NUM_STATES-1:0] hit_o
);

    line_t active_view;
    assign active_view = low_active ? ~hit_o : hit_o;

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> state_q == '0);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(state_q));

    assert_gray_succ_R3: assert property (@(posedge clk) disable iff (rst)
        step_en |=> state_q == gray_succ($past(state_q)));

    assert_single_flip_R4: assert property (@(posedge clk) disable iff (rst)
        step_en |=> $countones(state_q ^ $past(state_q)) == 1);

    assert_line_matches_R5: assert property (@(posedge clk) disable iff (rst)
        active_view[state_q] == 1'b1);

    assert_one_active_R7: assert property (@(posedge clk) disable iff (rst)
        $countones(active_view) == 1);

endmodule

bind gray3_jk_counter gray3_jk_counter_chk u_chk (.*);

// File: tb/tb_gray3_jk_counter.sv
`timescale 1ns/1ps
module tb_gray3_jk_counter;

    localparam realtime HALF = 2.0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic       low_active = 1'b0;
    logic [2:0] state_q;
    logic [7:0] hit_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference: Gray cycle as an ordered list, position tracked as integer
    int ring[$] = '{0, 1, 3, 2, 6, 7, 5, 4};
    int pos = 0;

    always #(HALF) clk = ~clk;

    gray3_jk_counter dut (
        .clk        (clk),
        .rst        (rst),
        .step_en    (step_en),
        .low_active (low_active),
        .state_q    (state_q),
        .hit_o      (hit_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_lines(input int code, input bit pol);
        int v;
        v = 1 << code;
        if (pol) v = (~v) & 8'hFF;
        return v;
    endfunction

    // one clock: inputs applied at negedge, outputs read 1 ns after posedge
    task automatic cycle(input bit r, input bit en, input bit pol, input string tag);
        int prev;
        prev = int'(state_q);
        @(negedge clk);
        rst = r; step_en = en; low_active = pol;
        @(posedge clk);
        if (r) pos = 0;
        else if (en) pos = (pos + 1) % 8;
        #1;
        chk(tag, int'(state_q), ring[pos]);
        chk("R5/R6/R7 lines", int'(hit_o), exp_lines(ring[pos], pol));
        chk("R7 one active", $countones(pol ? ~hit_o : hit_o), 1);
        if (!r && en) chk("R4 single flip", $countones(3'(prev) ^ state_q), 1);
        if (!r && !en) chk("R2 hold", int'(state_q), prev);
    endtask

    initial begin
        // R1: reset from time zero
        cycle(1, 0, 0, "R1 reset");
        cycle(1, 1, 0, "R1 reset with enable");
        chk("R1 reset lines", int'(hit_o), 8'h01);

        // R3/R9: full cycle plus wrap, active-high
        for (int i = 0; i < 10; i++) cycle(0, 1, 0, "R3 R9 step");

        // R2: hold mid-sequence
        for (int i = 0; i < 3; i++) cycle(0, 0, 0, "R2 hold");

        // R6: active-low polarity across a wrap
        for (int i = 0; i < 9; i++) cycle(0, 1, 1, "R6 R3 step low");

        // R8: polarity flips while holding, no edge needed
        @(negedge clk);
        step_en = 1'b0; low_active = 1'b0;
        #0.5;
        chk("R8 flip to high", int'(hit_o), exp_lines(ring[pos], 0));
        chk("R8 state kept", int'(state_q), ring[pos]);
        low_active = 1'b1;
        #0.5;
        chk("R8 flip to low", int'(hit_o), exp_lines(ring[pos], 1));
        chk("R8 state kept", int'(state_q), ring[pos]);

        // hold at wrap point (state 100), then step across
        while (ring[pos] != 4) cycle(0, 1, 0, "R3 seek wrap");
        cycle(0, 0, 0, "R2 hold at wrap");
        cycle(0, 1, 0, "R3 R4 wrap to zero");

        // mixed enable pattern with polarity swaps
        for (int i = 0; i < 40; i++)
            cycle(0, (i % 3) != 0, (i % 5) == 0, "R3 R2 mixed");

        // R1: reset overrides enable mid-sequence
        cycle(0, 1, 0, "R3 pre-reset");
        cycle(1, 1, 1, "R1 reset while enabled");
        cycle(0, 1, 0, "R3 after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4.0);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule